// File: doc/BRIEF.md
# Implication-Based Online Error Checker

This block watches a vector of internal signal sites taken from a monitored logic block and flags, while the block runs, any break in a logical relationship that must always hold between those sites. Three kinds of rule are fixed at elaboration through parameter arrays of site indices, expected values and operation codes.

The first kind is a two-site implication: when one site has a given value, another site must have a given value. The second is a residual implication: the same two-site rule, checked only while a pivot site holds its stated value. The third is a checking function: one site must equal a logic combination of two other sites, and the first of those two can be inverted.

Each rule drives one bit of a violation vector. The OR of that vector gives an immediate error bit. A sticky register captures the error and keeps it until reset or an explicit clear. An enable input masks all checking while the monitored block's values are not valid.

Top module: `impl_checker`

## Requirements
- R1: Two-site rule i (bit i of `viol`) is 1 exactly when `sites[IMP_A[i]] == IMP_AV[i]` and `sites[IMP_B[i]] != IMP_BV[i]`, while `en` is 1.
- R2: Residual rule j (bit `N_IMP+j` of `viol`) is 1 exactly when `sites[RES_P[j]] == RES_PV[j]`, `sites[RES_A[j]] == RES_AV[j]` and `sites[RES_B[j]] != RES_BV[j]`, while `en` is 1. When the pivot differs from its value, the rule never fires.
- R3: Function rule k (bit `N_IMP+N_RES+k` of `viol`) is 1 exactly when `sites[FUN_C[k]]` differs from `(sites[FUN_A[k]] ^ FUN_INV[k]) OP sites[FUN_B[k]]`, while `en` is 1. `FUN_OP` selects OP: 0 = AND, 1 = OR, any other value = XOR.
- R4: A two-site rule and its contrapositive (site B equal to the opposite of its value implies site A equal to the opposite of its value) give the same violation bit for every site pattern.
- R5: `err_now` is the OR of all bits of `viol`, in the same cycle and with no register.
- R6: At each rising clock edge where `en` is 1 and any rule is violated, `err` becomes 1. Otherwise it holds its value, unless `clr` is 1.
- R7: At a rising clock edge where `clr` is 1 and no enabled violation is present, `err` becomes 0. If a violation is present in that same cycle, the set wins and `err` stays 1.
- R8: While `en` is 0, all of `viol` and `err_now` are 0, and `err` does not become set.
- R9: While `rst_n` is 0, `err` is 0. Reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Checking enable; 0 masks all rules |
| clr | input | 1 | Clears the sticky error flag |
| sites | input | N_SITES | Monitored site values |
| viol | output | N_IMP+N_RES+N_FUN | Violation bit for each rule |
| err_now | output | 1 | OR of the violation bits in the current cycle |
| err | output | 1 | Sticky error flag |

## Verification
The only state in the block is the sticky flag. A wrong value there shows on `err` one clock edge after the cycle that caused it: a missed set, a clear that does not take effect, or a set while `en` is 0. The per-rule logic has no state, so a wrong site index, polarity or operation code shows on `viol` and `err_now` in the same cycle, for some site patterns. The bench drives every pattern of the eight monitored sites under several combinations of enable and clear, so that every rule's firing condition and every pivot value occurs.

// File: rtl/impl_checker.sv
module impl_checker #(
  parameter int N_SITES = 8,
  parameter int N_IMP   = 3,
  parameter int N_RES   = 2,
  parameter int N_FUN   = 3,
  parameter int unsigned IMP_A  [N_IMP] = '{0, 1, 2},
  parameter bit          IMP_AV [N_IMP] = '{1'b1, 1'b1, 1'b0},
  parameter int unsigned IMP_B  [N_IMP] = '{1, 0, 3},
  parameter bit          IMP_BV [N_IMP] = '{1'b0, 1'b0, 1'b0},
  parameter int unsigned RES_P  [N_RES] = '{4, 7},
  parameter bit          RES_PV [N_RES] = '{1'b0, 1'b1},
  parameter int unsigned RES_A  [N_RES] = '{5, 5},
  parameter bit          RES_AV [N_RES] = '{1'b1, 1'b0},
  parameter int unsigned RES_B  [N_RES] = '{6, 6},
  parameter bit          RES_BV [N_RES] = '{1'b1, 1'b0},
  parameter int unsigned FUN_A  [N_FUN] = '{0, 5, 0},
  parameter bit          FUN_INV[N_FUN] = '{1'b1, 1'b0, 1'b0},
  parameter int unsigned FUN_B  [N_FUN] = '{1, 6, 4},
  parameter int unsigned FUN_C  [N_FUN] = '{3, 7, 2},
  parameter int unsigned FUN_OP [N_FUN] = '{0, 2, 1},
  localparam int N_RULES = N_IMP + N_RES + N_FUN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [N_SITES-1:0] sites,
  output logic [N_RULES-1:0] viol,
  output logic               err_now,
  output logic               err
);

  logic [N_RULES-1:0] raw;

  for (genvar i = 0; i < N_IMP; i++) begin : g_imp
    assign raw[i] = (sites[IMP_A[i]] == IMP_AV[i]) && (sites[IMP_B[i]] != IMP_BV[i]);
  end

  for (genvar j = 0; j < N_RES; j++) begin : g_res
    assign raw[N_IMP+j] = (sites[RES_P[j]] == RES_PV[j]) &&
                          (sites[RES_A[j]] == RES_AV[j]) &&
                          (sites[RES_B[j]] != RES_BV[j]);
  end

  for (genvar k = 0; k < N_FUN; k++) begin : g_fun
    logic a_in, f_val;
    assign a_in = sites[FUN_A[k]] ^ FUN_INV[k];
    if (FUN_OP[k] == 0) begin : g_and
      assign f_val = a_in & sites[FUN_B[k]];
    end else if (FUN_OP[k] == 1) begin : g_or
      assign f_val = a_in | sites[FUN_B[k]];
    end else begin : g_xor
      assign f_val = a_in ^ sites[FUN_B[k]];
    end
    assign raw[N_IMP+N_RES+k] = sites[FUN_C[k]] != f_val;
  end

  assign viol    = en ? raw : '0;
  assign err_now = |viol;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       err <= 1'b0;
    else if (err_now) err <= 1'b1;
    else if (clr)     err <= 1'b0;

endmodule

module impl_checker_chk #(parameter int N_RULES = 8) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               clr,
  input logic [N_RULES-1:0] viol,
  input logic               err_now,
  input logic               err
);
  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (viol != '0)) |=> err);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !err_now) |=> $stable(err));
  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (viol == '0)) |=> !err);
  // R8
  en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (viol == '0 && !err_now));
  // R8
  no_set_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !err) |=> !err);
endmodule

bind impl_checker impl_checker_chk #(.N_RULES(N_RULES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
  .viol(viol), .err_now(err_now), .err(err)
);

// File: tb/test_impl_checker.sv
module test_impl_checker;
  localparam int NR = 8;
  int ia[3] = '{0,1,2};  bit iav[3] = '{1,1,0};
  int ib[3] = '{1,0,3};  bit ibv[3] = '{0,0,0};
  int rp[2] = '{4,7};    bit rpv[2] = '{0,1};
  int ra[2] = '{5,5};    bit rav[2] = '{1,0};
  int rb[2] = '{6,6};    bit rbv[2] = '{1,0};
  int fa[3] = '{0,5,0};  bit finv[3] = '{1,0,0};
  int fb[3] = '{1,6,4};  int fc[3] = '{3,7,2};  int fop[3] = '{0,2,1};

  logic clk = 0, rst_n = 0, en = 0, clr = 0;
  logic [7:0] sites = '0;
  logic [NR-1:0] viol;
  logic err_now, err;
  int total = 0, bad = 0;
  bit m_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  impl_checker i_impl_checker (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
    .sites(sites), .viol(viol), .err_now(err_now), .err(err));

  function automatic logic [NR-1:0] model(logic [7:0] s, logic e);
    logic [NR-1:0] v = '0;
    bit a, f;
    if (!e) return '0;
    for (int i = 0; i < 3; i++) v[i] = (s[ia[i]] == iav[i]) && (s[ib[i]] != ibv[i]);
    for (int j = 0; j < 2; j++)
      v[3+j] = (s[rp[j]] == rpv[j]) && (s[ra[j]] == rav[j]) && (s[rb[j]] != rbv[j]);
    for (int k = 0; k < 3; k++) begin
      a = s[fa[k]] ^ finv[k];
      case (fop[k])
        0: f = a & s[fb[k]];
        1: f = a | s[fb[k]];
        default: f = a ^ s[fb[k]];
      endcase
      v[5+k] = s[fc[k]] != f;
    end
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h sites=%0h en=%0b clr=%0b", req, act, exp, sites, en, clr);
    end
  endtask

  task automatic step(logic [7:0] s, logic e, logic c);
    logic [NR-1:0] ev;
    @(negedge clk);
    sites = s; en = e; clr = c;
    #1;
    ev = model(s, e);
    chk("R1", {29'd0, viol[2:0]}, {29'd0, ev[2:0]});
    chk("R2", {30'd0, viol[4:3]}, {30'd0, ev[4:3]});
    chk("R3", {29'd0, viol[7:5]}, {29'd0, ev[7:5]});
    chk("R4", {31'd0, viol[0]}, {31'd0, viol[1]});
    chk("R5", {31'd0, err_now}, {31'd0, |ev});
    chk(e ? "R6" : "R8", {31'd0, err}, {31'd0, m_err});
    m_err = (|ev) ? 1'b1 : (c ? 1'b0 : m_err);
  endtask

  initial begin
    #1;
    chk("R9", {31'd0, err}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9", {31'd0, err}, 32'd0);
    rst_n = 1;
    // R8: masked sweep, err must stay low
    for (int p = 0; p < 256; p++) step(p[7:0], 1'b0, 1'b0);
    // R1 R2 R3 R6 R7: enabled sweep, clear every cycle
    for (int p = 0; p < 256; p++) step(p[7:0], 1'b1, 1'b1);
    // R6: enabled sweep without clear, sticky
    for (int p = 255; p >= 0; p--) step(p[7:0], 1'b1, 1'b0);
    // R7: clear while masked
    step(8'h00, 1'b0, 1'b1);
    step(8'h00, 1'b0, 1'b0);
    chk("R7", {31'd0, err}, 32'd0);
    // R6 then R9: set, then async reset
    step(8'h01, 1'b1, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    chk("R6", {31'd0, err}, 32'd1);
    rst_n = 0; #1;
    chk("R9", {31'd0, err}, 32'd0);
    m_err = 0;
    @(negedge clk); rst_n = 1;
    // mixed patterns with en and clr toggling
    for (int p = 0; p < 512; p++) step(p[7:0] ^ 8'h5a, p[1] | p[3], p[2]);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule